// File: doc/BRIEF.md
# Text Display Controller Register Port with Cursor Geometry

This block is the host-facing register port of a text-mode display controller. A byte-wide I/O bus with a 3-bit port offset, a read strobe and a write strobe reaches three ports: an index latch, a data window, and a status byte. The data window reads and writes whichever of 256 byte registers the index latch points at. Reading the status byte flips its lowest bit and returns the flipped value. Software polls this bit to see activity.

Four of the stored registers describe the hardware cursor. From them the block derives the cursor's pixel box on an 80-column grid of 8x8 character cells: the top and bottom scanlines, the left and right pixel columns, and an enable flag. A 16-bit linear cursor location is split into row and column by a sequential divide-by-80. The geometry outputs are registered. They keep their previous values until a new result is complete, and `cur_valid` shows when they match the latest register writes.

Top module: `vidctl_regport`

## Requirements
- R1: A write with `io_off` = 0 latches `io_wdata` as the register index. A read with `io_off` = 0 returns the current index.
- R2: A write with `io_off` = 1 stores the byte into register entry [index]. A read with `io_off` = 1 returns that entry. All 256 entries are independent.
- R3: After reset the index is 0, every entry is 0, the status bit is 0, and the cursor outputs are top 0, bottom 0, left 0, right 8, enabled, and valid.
- R4: A read with `io_off` = 6 inverts status bit 0 and returns the new value, with bits 7:1 zero. A read strobe held high for several cycles counts as one read.
- R5: Reads with `io_off` equal to 2, 3, 4, 5 or 7 return 0. Writes with `io_off` equal to 2, 3, 4, 5, 6 or 7 change neither the index, the entries nor the status bit.
- R6: Read data is registered. It appears in the cycle after the first strobe cycle and holds until the next read starts.
- R7: The location is {entry 0x0E, entry 0x0F}. With row = location / 80 and column = location mod 80, `cur_left` = column*8 and `cur_right` = column*8 + 8.
- R8: `cur_top` = row*8 + entry 0x0A bits 3:0, and `cur_bot` = row*8 + entry 0x0B bits 3:0.
- R9: `cur_en` is 0 only when entry 0x0A bits 5:4 equal 2'b01. Any other value enables the cursor.
- R10: A data-window write to entry 0x0A, 0x0B, 0x0E or 0x0F drops `cur_valid` in the next cycle. The geometry outputs hold their old values while `cur_valid` is low. `cur_valid` returns within 24 cycles with outputs that reflect every such write, including writes made while a computation was running.
- R11: Data-window writes to any other entry leave `cur_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_off | input | 3 | Port offset within the 8-port window |
| io_rd | input | 1 | Read strobe; only its first cycle acts |
| io_wr | input | 1 | Write strobe; acts in each cycle it is high |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cur_top | output | 13 | Cursor top scanline |
| cur_bot | output | 13 | Cursor bottom scanline |
| cur_left | output | 10 | Cursor left pixel column |
| cur_right | output | 10 | Cursor right pixel column |
| cur_en | output | 1 | Cursor enable |
| cur_valid | output | 1 | Geometry matches the latest cursor register writes |

## Verification
A new host write to a cursor register can arrive while the divide for an earlier write is still in progress. The bench provokes this by writing the high location byte, letting the divider run a few cycles, and then writing the low byte. It also puts the last cursor write back to back with earlier ones during every cursor update. It judges the result on two points. First, the geometry must not move while `cur_valid` is low. Second, the final geometry, computed arithmetically from the last values written, must be correct once `cur_valid` rises.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    localparam int GRID_COLS = 80;
    localparam int CELL_PX   = 8;
    localparam int LOC_W     = 16;
    localparam int SCAN_W    = 4;
    localparam int NREG      = 256;
    localparam int IDX_W     = $clog2(NREG);

    localparam int ROW_MAX   = ((1 << LOC_W) - 1) / GRID_COLS;
    localparam int COL_W     = $clog2(GRID_COLS);
    localparam int Y_W       = $clog2(ROW_MAX * CELL_PX + (1 << SCAN_W));
    localparam int X_W       = $clog2(GRID_COLS * CELL_PX + 1);

    typedef enum logic [2:0] {
        PORT_INDEX  = 3'd0,
        PORT_DATA   = 3'd1,
        PORT_STATUS = 3'd6
    } port_sel_e;

    localparam logic [7:0] REG_SCAN_TOP = 8'h0A;
    localparam logic [7:0] REG_SCAN_BOT = 8'h0B;
    localparam logic [7:0] REG_LOC_HI   = 8'h0E;
    localparam logic [7:0] REG_LOC_LO   = 8'h0F;

    typedef struct packed {
        logic [Y_W-1:0] top;
        logic [Y_W-1:0] bot;
        logic [X_W-1:0] left;
        logic [X_W-1:0] right;
        logic           en;
    } cur_geom_t;

    function automatic logic is_cursor_reg(input logic [7:0] idx);
        return (idx == REG_SCAN_TOP) || (idx == REG_SCAN_BOT) ||
               (idx == REG_LOC_HI)   || (idx == REG_LOC_LO);
    endfunction

    function automatic logic hide_code(input logic [1:0] fld);
        return fld == 2'b01;
    endfunction

endpackage

// File: rtl/vidctl_bus.sv
module vidctl_bus
    import vidctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        off,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [7:0]        idx,
    output logic [5:0]        scan_top_fld,
    output logic [SCAN_W-1:0] scan_bot_fld,
    output logic [LOC_W-1:0]  loc
);

    logic [7:0] regs [NREG];
    logic       stat_q;
    logic       rd_q;
    logic       rd_first;

    assign rd_first = rd && !rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            stat_q <= 1'b0;
            rd_q   <= 1'b0;
            rdata  <= '0;
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else begin
            rd_q <= rd;
            if (wr) begin
                case (off)
                    PORT_INDEX: idx <= wdata;
                    PORT_DATA:  regs[idx[IDX_W-1:0]] <= wdata;
                    default: ;
                endcase
            end
            if (rd_first) begin
                case (off)
                    PORT_INDEX:  rdata <= idx;
                    PORT_DATA:   rdata <= regs[idx[IDX_W-1:0]];
                    PORT_STATUS: begin
                        stat_q <= ~stat_q;
                        rdata  <= {7'b0, ~stat_q};
                    end
                    default:     rdata <= '0;
                endcase
            end
        end
    end

    assign scan_top_fld = regs[REG_SCAN_TOP][5:0];
    assign scan_bot_fld = regs[REG_SCAN_BOT][SCAN_W-1:0];
    assign loc          = {regs[REG_LOC_HI], regs[REG_LOC_LO]};

endmodule

// File: rtl/vidctl_div.sv
module vidctl_div #(
    parameter int WIDTH   = 16,
    parameter int DIVISOR = 80,
    localparam int RW     = $clog2(DIVISOR),
    localparam int CW     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    output logic             done,
    output logic [WIDTH-1:0] quo,
    output logic [RW-1:0]    rem
);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [RW:0]   shifted;
    logic [RW:0]   trial;
    logic          fits;

    assign shifted = {rem, quo[WIDTH-1]};
    assign fits    = shifted >= (RW+1)'(DIVISOR);
    assign trial   = shifted - (RW+1)'(DIVISOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            quo  <= '0;
            rem  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
                quo  <= dividend;
                rem  <= '0;
            end else if (busy) begin
                rem <= fits ? trial[RW-1:0] : shifted[RW-1:0];
                quo <= {quo[WIDTH-2:0], fits};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(WIDTH - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vidctl_cursor.sv
module vidctl_cursor
    import vidctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_wr,
    input  logic [5:0]        scan_top_fld,
    input  logic [SCAN_W-1:0] scan_bot_fld,
    input  logic [LOC_W-1:0]  loc,
    output cur_geom_t         geom,
    output logic              valid
);

    logic             pend;
    logic             done;
    logic [LOC_W-1:0] quo;
    logic [COL_W-1:0] rem;
    logic             commit;
    logic [Y_W-1:0]   row_y;
    logic [X_W-1:0]   col_x;

    vidctl_div #(
        .WIDTH  (LOC_W),
        .DIVISOR(GRID_COLS)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .start   (pend),
        .dividend(loc),
        .done    (done),
        .quo     (quo),
        .rem     (rem)
    );

    assign commit = done && !pend && !cur_wr;
    assign row_y  = Y_W'(quo) * Y_W'(CELL_PX);
    assign col_x  = X_W'(rem) * X_W'(CELL_PX);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            valid      <= 1'b1;
            geom.top   <= '0;
            geom.bot   <= '0;
            geom.left  <= '0;
            geom.right <= X_W'(CELL_PX);
            geom.en    <= 1'b1;
        end else begin
            pend <= cur_wr;
            if (cur_wr) begin
                valid <= 1'b0;
            end else if (commit) begin
                valid      <= 1'b1;
                geom.top   <= row_y + Y_W'(scan_top_fld[SCAN_W-1:0]);
                geom.bot   <= row_y + Y_W'(scan_bot_fld);
                geom.left  <= col_x;
                geom.right <= col_x + X_W'(CELL_PX);
                geom.en    <= !hide_code(scan_top_fld[5:4]);
            end
        end
    end

endmodule

// File: rtl/vidctl_regport.sv
module vidctl_regport
    import vidctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     io_off,
    input  logic           io_rd,
    input  logic           io_wr,
    input  logic [7:0]     io_wdata,
    output logic [7:0]     io_rdata,
    output logic [Y_W-1:0] cur_top,
    output logic [Y_W-1:0] cur_bot,
    output logic [X_W-1:0] cur_left,
    output logic [X_W-1:0] cur_right,
    output logic           cur_en,
    output logic           cur_valid
);

    logic [7:0]        bus_idx;
    logic [5:0]        scan_top_fld;
    logic [SCAN_W-1:0] scan_bot_fld;
    logic [LOC_W-1:0]  loc;
    logic              cur_wr;
    cur_geom_t         geom;

    vidctl_bus u_bus (
        .clk         (clk),
        .rst         (rst),
        .off         (io_off),
        .rd          (io_rd),
        .wr          (io_wr),
        .wdata       (io_wdata),
        .rdata       (io_rdata),
        .idx         (bus_idx),
        .scan_top_fld(scan_top_fld),
        .scan_bot_fld(scan_bot_fld),
        .loc         (loc)
    );

    assign cur_wr = io_wr && (io_off == PORT_DATA) && is_cursor_reg(bus_idx);

    vidctl_cursor u_cursor (
        .clk         (clk),
        .rst         (rst),
        .cur_wr      (cur_wr),
        .scan_top_fld(scan_top_fld),
        .scan_bot_fld(scan_bot_fld),
        .loc         (loc),
        .geom        (geom),
        .valid       (cur_valid)
    );

    assign cur_top   = geom.top;
    assign cur_bot   = geom.bot;
    assign cur_left  = geom.left;
    assign cur_right = geom.right;
    assign cur_en    = geom.en;

endmodule

// File: rtl/vidctl_regport_chk.sv
module vidctl_regport_chk
    import vidctl_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [2:0]     io_off,
    input logic           io_rd,
    input logic           io_wr,
    input logic [7:0]     io_rdata,
    input logic [7:0]     bus_idx,
    input logic [Y_W-1:0] cur_top,
    input logic [Y_W-1:0] cur_bot,
    input logic [X_W-1:0] cur_left,
    input logic [X_W-1:0] cur_right,
    input logic           cur_en,
    input logic           cur_valid
);

    logic rd_prev;
    always_ff @(posedge clk) begin
        if (rst) rd_prev <= 1'b0;
        else     rd_prev <= io_rd;
    end

    // R4: status reads return zero in bits 7:1
    a_r4_status_upper: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !rd_prev && io_off == 3'd6) |=> (io_rdata[7:1] == 7'd0));

    // R4, R6: a held strobe does not start a new read
    a_r6_held_read: assert property (@(posedge clk) disable iff (rst)
        (io_rd && rd_prev) |=> $stable(io_rdata));

    // R5: unmapped offsets read as zero
    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !rd_prev && io_off != 3'd0 && io_off != 3'd1 && io_off != 3'd6)
        |=> (io_rdata == 8'd0));

    // R10: a cursor register write drops valid
    a_r10_drop: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_off == 3'd1 && is_cursor_reg(bus_idx)) |=> !cur_valid);

    // R10: outputs hold while invalid
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !cur_valid |=> (cur_valid || ($stable(cur_top) && $stable(cur_bot) &&
                        $stable(cur_left) && $stable(cur_right) && $stable(cur_en))));

    // R7: cell span and column range
    a_r7_span: assert property (@(posedge clk) disable iff (rst)
        (cur_right == cur_left + X_W'(CELL_PX)) && (cur_left < X_W'(GRID_COLS * CELL_PX)));

endmodule

bind vidctl_regport vidctl_regport_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .io_off   (io_off),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .bus_idx  (bus_idx),
    .cur_top  (cur_top),
    .cur_bot  (cur_bot),
    .cur_left (cur_left),
    .cur_right(cur_right),
    .cur_en   (cur_en),
    .cur_valid(cur_valid)
);

// File: tb/test_vidctl_regport.sv
module test_vidctl_regport;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  io_off = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [12:0] cur_top, cur_bot;
    logic [9:0]  cur_left, cur_right;
    logic        cur_en, cur_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic stat_m = 1'b0;
    int p_top = 0, p_bot = 0, p_left = 0, p_right = 8, p_en = 1;

    always #2.5 clk = ~clk;

    vidctl_regport i_vidctl_regport (
        .clk(clk), .rst(rst), .io_off(io_off), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cur_top(cur_top),
        .cur_bot(cur_bot), .cur_left(cur_left), .cur_right(cur_right),
        .cur_en(cur_en), .cur_valid(cur_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int off, input int data);
        @(negedge clk);
        io_off = 3'(off); io_wdata = 8'(data); io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input int off, output int data);
        @(negedge clk);
        io_off = 3'(off); io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        data = int'(io_rdata);
        @(negedge clk);
    endtask

    task automatic set_reg(input int r, input int v);
        bus_wr(0, r);
        bus_wr(1, v);
    endtask

    task automatic cursor_case(input int loc, input int ss, input int se, input int gap);
        int row, col, e_top, e_bot, e_left, e_en, waited;
        bit held;
        row = loc / 80; col = loc % 80;
        e_top = row * 8 + (ss & 15);
        e_bot = row * 8 + (se & 15);
        e_left = col * 8;
        e_en = (((ss >> 4) & 3) != 1) ? 1 : 0;
        set_reg(8'h0A, ss);
        check("R10 valid drops after cursor write", int'(cur_valid), 0);
        set_reg(8'h0B, se);
        bus_wr(0, 8'h0E);
        bus_wr(1, loc >> 8);
        repeat (gap) @(negedge clk);
        bus_wr(0, 8'h0F);
        bus_wr(1, loc & 255);
        held = 1; waited = 0;
        while (!cur_valid && waited < 24) begin
            if (cur_top != 13'(p_top) || cur_bot != 13'(p_bot) || cur_left != 10'(p_left) ||
                cur_right != 10'(p_right) || int'(cur_en) != p_en) held = 0;
            @(negedge clk);
            waited++;
        end
        check("R10 outputs held while invalid", int'(held), 1);
        check("R10 valid returns", int'(cur_valid), 1);
        check("R7 left", int'(cur_left), e_left);
        check("R7 right", int'(cur_right), e_left + 8);
        check("R8 top", int'(cur_top), e_top);
        check("R8 bottom", int'(cur_bot), e_bot);
        check("R9 enable", int'(cur_en), e_en);
        p_top = e_top; p_bot = e_bot; p_left = e_left; p_right = e_left + 8; p_en = e_en;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check("R3 top", int'(cur_top), 0);
        check("R3 bottom", int'(cur_bot), 0);
        check("R3 left", int'(cur_left), 0);
        check("R3 right", int'(cur_right), 8);
        check("R3 enable", int'(cur_en), 1);
        check("R3 valid", int'(cur_valid), 1);
        bus_rd(0, d); check("R3 index reset", d, 0);
        for (int r = 0; r < 256; r++) begin
            bus_wr(0, r);
            bus_rd(1, d); check("R3 entry reset", d, 0);
        end

        // R1 index readback across all values
        for (int v = 0; v < 256; v++) begin
            bus_wr(0, v);
            bus_rd(0, d); check("R1 index readback", d, v);
        end

        // R2 fill every entry then read back (avoiding cursor regs changes is not needed)
        for (int r = 0; r < 256; r++) set_reg(r, (r * 37 + 11) & 255);
        for (int r = 0; r < 256; r++) begin
            bus_wr(0, r);
            bus_rd(1, d); check("R2 entry readback", d, (r * 37 + 11) & 255);
        end
        // restore cursor registers to zero and resynchronise the model
        set_reg(8'h0A, 0); set_reg(8'h0B, 0); set_reg(8'h0E, 0); set_reg(8'h0F, 0);
        while (!cur_valid) @(negedge clk);
        p_top = 0; p_bot = 0; p_left = 0; p_right = 8; p_en = 1;

        // R4 status toggles on each read
        for (int k = 0; k < 6; k++) begin
            stat_m = ~stat_m;
            bus_rd(6, d); check("R4 status toggle", d, int'(stat_m));
        end
        // R4, R6 held read counts once and data holds
        @(negedge clk);
        io_off = 3'd6; io_rd = 1'b1;
        @(negedge clk);
        stat_m = ~stat_m;
        check("R6 data after first strobe cycle", int'(io_rdata), int'(stat_m));
        repeat (5) begin
            @(negedge clk);
            check("R6 data holds during held strobe", int'(io_rdata), int'(stat_m));
        end
        io_rd = 1'b0;
        @(negedge clk);
        stat_m = ~stat_m;
        bus_rd(6, d); check("R4 held read toggled once", d, int'(stat_m));

        // R5 unmapped offsets
        set_reg(8'h20, 8'h5A);
        for (int o = 2; o < 8; o++) begin
            if (o != 6) begin
                bus_rd(o, d); check("R5 unmapped read zero", d, 0);
            end
            bus_wr(o, 8'hFF);
            bus_rd(0, d); check("R5 index untouched", d, 8'h20);
            bus_rd(1, d); check("R5 entry untouched", d, 8'h5A);
        end
        stat_m = ~stat_m;
        bus_rd(6, d); check("R5 status untouched by writes", d, int'(stat_m));

        // R11 non-cursor register write keeps valid
        bus_wr(0, 8'h0C);
        bus_wr(1, 8'h77);
        check("R11 valid kept", int'(cur_valid), 1);
        bus_wr(0, 8'h0D);
        bus_wr(1, 8'h12);
        check("R11 valid kept", int'(cur_valid), 1);

        // R7-R10 cursor sweep, including writes during a running divide
        cursor_case(0, 8'h00, 8'h07, 0);
        cursor_case(79, 8'h10, 8'h0F, 0);
        cursor_case(80, 8'h20, 8'h03, 6);
        cursor_case(1999, 8'h3F, 8'hF5, 3);
        cursor_case(65535, 8'h0E, 8'h0F, 10);
        cursor_case(65520, 8'hD1, 8'h00, 0);
        for (int i = 0; i < 400; i++) begin
            cursor_case((i * 163 + i * i * 7) & 16'hFFFF, i & 63, (i * 7 + (i >> 2)) & 255, i % 12);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule